// File: doc/BRIEF.md
# Paged Address Translator with Page-State Tracking

This block maps CPU addresses in the low region of the address space onto physical pages. The logical page number is looked up in an internal table of 16-bit entries. The physical page number from the entry replaces the logical page number, and the offset inside the page is kept. Every access in that region also advances a two-bit per-page state: a page that has never been touched becomes "read" or "dirty", and a page that has been read becomes "dirty" once it is written. The updated entry is written back in the same cycle as the lookup. Addresses at or above the translated region leave the block unchanged and do not touch the table.

The table is also visible to the CPU on a separate port. The CPU can write whole 16-bit words or single bytes and can read whole words. Only the low bits of the CPU byte address select an entry, so the table repeats across the port's address space. Checking access rights and reporting faults belong to another block. This one only translates and tracks page state.

Top module: `page_xlate`

## Requirements
- R1: An access with address at or above 0x400000 yields that same address on `xl_addr` and leaves every table entry unchanged.
- R2: An access below 0x400000 yields, one clock later, `xl_addr` = {entry bits 9:0, address bits 11:0}, with upper bits zero. The entry is selected by address bits 21:12. `xl_valid` is high exactly in the cycle after an access.
- R3: A read of a page in state 1 (entry bits 14:13) sets it to state 2. A write of a page in state 1 sets it to state 3.
- R4: A write of a state-2 page sets it to state 3. A read of a state-2 or state-3 page, and a write of a state-3 page, leave the entry unchanged.
- R5: An access to a page in state 0 leaves its entry unchanged.
- R6: A state update changes only bits 14:13. Bit 15 (the write-enable flag) and bits 12:0 keep their values.
- R7: A CPU word write stores `map_wdata` into the entry. A CPU byte write stores `map_wdata[7:0]` into bits 15:8 at an even address and into bits 7:0 at an odd address. A CPU read returns the whole entry on `map_rdata` one clock later.
- R8: The CPU port selects the entry with byte-address bits 10:1 and ignores every higher bit, so the table repeats every 2 KB.
- R9: When a CPU write and a state update hit the same entry in the same cycle, the CPU write wins. The translation in that cycle still uses the old entry. Updates and CPU writes to different entries both take effect.
- R10: After reset `xl_valid` is low, `map_rdata` is zero and every entry is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 24 | Logical address of the access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| xl_valid | output | 1 | Translated address valid |
| xl_addr | output | 24 | Translated (or passed-through) address |
| map_req | input | 1 | CPU table-port request |
| map_wr | input | 1 | 1 = write, 0 = read |
| map_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| map_addr | input | 24 | CPU byte address into the table |
| map_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| map_rdata | output | 16 | Registered read data |

## Verification
The bench fills every entry through the CPU port. It then sweeps all 1024 pages with reads, then with writes, then with reads again, so that every starting state meets both access kinds. A design that mixed up the read and write transitions, or that updated absent pages, would leave entries that differ on readback. Pass-through addresses are chosen so that their bits 21:12 land on pages in state 1. A block that failed to gate on the region limit would then change those entries. Other cases cover big-endian byte lanes, accesses through mirrored addresses, back-to-back accesses to one page, and a CPU write that collides with a state update to the same entry. A wrong priority in the collision case would lose the CPU data.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

    localparam int ENTRY_W = 16;
    localparam int WE_BIT  = 15;
    localparam int ST_HI   = 14;
    localparam int ST_LO   = 13;

    typedef logic [ENTRY_W-1:0] map_entry_t;

    typedef enum logic [1:0] {
        PG_ABSENT = 2'd0,
        PG_FRESH  = 2'd1,
        PG_READ   = 2'd2,
        PG_DIRTY  = 2'd3
    } pg_state_e;

endpackage

// File: rtl/pxl_state_next.sv
module pxl_state_next
    import pxl_pkg::*;
(
    input  logic       valid_i,
    input  logic       write_i,
    input  map_entry_t entry_i,
    output logic       upd_o,
    output map_entry_t entry_o
);

    pg_state_e st_now;
    pg_state_e st_nxt;

    always_comb begin
        st_now = pg_state_e'(entry_i[ST_HI:ST_LO]);
        st_nxt = st_now;
        unique case (st_now)
            PG_FRESH: st_nxt = write_i ? PG_DIRTY : PG_READ;
            PG_READ:  st_nxt = write_i ? PG_DIRTY : PG_READ;
            default:  st_nxt = st_now;
        endcase
        entry_o               = entry_i;
        entry_o[ST_HI:ST_LO]  = st_nxt;
        upd_o = valid_i && (st_now != PG_ABSENT) && (st_nxt != st_now);
    end

endmodule

// File: rtl/pxl_map_array.sv
module pxl_map_array
    import pxl_pkg::*;
#(
    parameter int PAGE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] rd_idx_a,
    output map_entry_t        rd_data_a,
    input  logic [PAGE_W-1:0] rd_idx_b,
    output map_entry_t        rd_data_b,
    input  logic              upd_en,
    input  logic [PAGE_W-1:0] upd_idx,
    input  map_entry_t        upd_data,
    input  logic              cpu_we,
    input  logic [PAGE_W-1:0] cpu_idx,
    input  logic [1:0]        cpu_be,
    input  map_entry_t        cpu_data
);

    localparam int DEPTH = 1 << PAGE_W;

    map_entry_t ents [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        map_entry_t ent_d;
        map_entry_t ent_q;

        // CPU writes outrank the state write-back on the same entry
        always_comb begin
            ent_d = ent_q;
            if (cpu_we && (cpu_idx == PAGE_W'(i))) begin
                if (cpu_be[1]) ent_d[15:8] = cpu_data[15:8];
                if (cpu_be[0]) ent_d[7:0]  = cpu_data[7:0];
            end else if (upd_en && (upd_idx == PAGE_W'(i))) begin
                ent_d = upd_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign ents[i] = ent_q;
    end

    assign rd_data_a = ents[rd_idx_a];
    assign rd_data_b = ents[rd_idx_b];

endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import pxl_pkg::*;
#(
    parameter int                ADDR_W      = 24,
    parameter int                PAGE_W      = 10,
    parameter int                OFS_W       = 12,
    parameter logic [ADDR_W-1:0] XLATE_LIMIT = 24'h40_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              xl_valid,
    output logic [ADDR_W-1:0] xl_addr,
    input  logic              map_req,
    input  logic              map_wr,
    input  logic              map_word,
    input  logic [ADDR_W-1:0] map_addr,
    input  logic [15:0]       map_wdata,
    output logic [15:0]       map_rdata
);

    localparam int IDX_LO = OFS_W;
    localparam int IDX_HI = OFS_W + PAGE_W - 1;

    typedef struct packed {
        logic              xv;
        logic [ADDR_W-1:0] xa;
        logic [15:0]       rd;
    } regs_t;

    regs_t r_d, r_q;

    logic              in_range;
    logic [PAGE_W-1:0] acc_idx;
    logic [PAGE_W-1:0] cpu_idx;
    logic [1:0]        cpu_be;
    map_entry_t        cpu_data;
    logic              cpu_we;
    map_entry_t        cur_entry;
    map_entry_t        upd_entry;
    map_entry_t        cpu_rd_entry;
    logic              upd_en;
    logic              unused_hi;

    assign in_range = acc_addr < XLATE_LIMIT;
    assign acc_idx  = acc_addr[IDX_HI:IDX_LO];

    // table port: entry picked by byte-address bits above bit 0, higher bits mirror
    assign cpu_idx   = map_addr[PAGE_W:1];
    assign cpu_we    = map_req && map_wr;
    assign cpu_be    = map_word ? 2'b11 : (map_addr[0] ? 2'b01 : 2'b10);
    assign cpu_data  = map_word ? map_wdata : {map_wdata[7:0], map_wdata[7:0]};
    assign unused_hi = ^map_addr[ADDR_W-1:PAGE_W+1];

    pxl_state_next u_next (
        .valid_i (acc_valid && in_range),
        .write_i (acc_write),
        .entry_i (cur_entry),
        .upd_o   (upd_en),
        .entry_o (upd_entry)
    );

    pxl_map_array #(.PAGE_W(PAGE_W)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_a  (acc_idx),
        .rd_data_a (cur_entry),
        .rd_idx_b  (cpu_idx),
        .rd_data_b (cpu_rd_entry),
        .upd_en    (upd_en),
        .upd_idx   (acc_idx),
        .upd_data  (upd_entry),
        .cpu_we    (cpu_we),
        .cpu_idx   (cpu_idx),
        .cpu_be    (cpu_be),
        .cpu_data  (cpu_data)
    );

    always_comb begin
        r_d    = r_q;
        r_d.xv = acc_valid;
        if (acc_valid) begin
            if (in_range) r_d.xa = ADDR_W'({cur_entry[PAGE_W-1:0], acc_addr[OFS_W-1:0]});
            else          r_d.xa = acc_addr;
        end
        if (map_req && !map_wr) r_d.rd = cpu_rd_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign xl_valid  = r_q.xv;
    assign xl_addr   = r_q.xa;
    assign map_rdata = r_q.rd;

endmodule

// File: rtl/pxl_checker.sv
module pxl_checker #(
    parameter int                ADDR_W      = 24,
    parameter int                OFS_W       = 12,
    parameter logic [ADDR_W-1:0] XLATE_LIMIT = 24'h40_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_write,
    input logic              xl_valid,
    input logic [ADDR_W-1:0] xl_addr,
    input logic              upd_en,
    input logic [15:0]       cur_entry,
    input logic [15:0]       upd_entry
);

    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr >= XLATE_LIMIT) |=> (xl_addr == $past(acc_addr)));

    p_no_upd_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> (acc_valid && acc_addr < XLATE_LIMIT));

    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> xl_valid);

    p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !xl_valid);

    p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (xl_addr[OFS_W-1:0] == $past(acc_addr[OFS_W-1:0])));

    p_write_dirty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && acc_write) |-> (upd_entry[14:13] == 2'b11));

    p_absent_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> (cur_entry[14:13] != 2'b00));

    p_keep_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> (upd_entry[15] == cur_entry[15] && upd_entry[12:0] == cur_entry[12:0]));

endmodule

bind page_xlate pxl_checker #(
    .ADDR_W      (ADDR_W),
    .OFS_W       (OFS_W),
    .XLATE_LIMIT (XLATE_LIMIT)
) u_chk (.*);

// File: tb/sim_page_xlate.sv
`timescale 1ns/1ps
module sim_page_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        xl_valid;
    logic [23:0] xl_addr;
    logic        map_req = 1'b0;
    logic        map_wr = 1'b0;
    logic        map_word = 1'b1;
    logic [23:0] map_addr = '0;
    logic [15:0] map_wdata = '0;
    logic [15:0] map_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [15:0] model [1024];

    always #4 clk = ~clk;

    page_xlate u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_next(input logic [15:0] e, input logic wr);
        logic [15:0] r;
        r = e;
        if (e[14:13] == 2'd1)                r[14:13] = wr ? 2'd3 : 2'd2;
        else if (e[14:13] == 2'd2 && wr)     r[14:13] = 2'd3;
        return r;
    endfunction

    function automatic logic [15:0] fill_val(input int i);
        return {i[0], 2'(i % 4), 3'b101, 10'((i * 37 + 11) % 1024)};
    endfunction

    task automatic cpu_wr(input logic [23:0] a, input logic [15:0] d, input logic word);
        @(negedge clk);
        map_req = 1'b1; map_wr = 1'b1; map_word = word; map_addr = a; map_wdata = d;
        @(negedge clk);
        map_req = 1'b0; map_wr = 1'b0;
    endtask

    task automatic cpu_rd(input logic [23:0] a, output logic [15:0] d);
        @(negedge clk);
        map_req = 1'b1; map_wr = 1'b0; map_word = 1'b1; map_addr = a;
        @(negedge clk);
        map_req = 1'b0;
        d = map_rdata;
    endtask

    task automatic access(input logic [23:0] a, input logic wr,
                          output logic [23:0] xa, output logic xv);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr;
        @(negedge clk);
        acc_valid = 1'b0;
        xa = xl_addr; xv = xl_valid;
    endtask

    task automatic sweep(input logic wr, input string tag);
        logic [23:0] a, xa;
        logic        xv;
        logic [15:0] rd;
        for (int p = 0; p < 1024; p++) begin
            a = {2'b00, 10'(p), 12'((p * 91 + 5) % 4096)};
            access(a, wr, xa, xv);
            chk({"R2 valid ", tag}, 32'(xv), 32'd1);
            chk({"R2 xlate ", tag}, 32'(xa), 32'({2'b00, model[p][9:0], a[11:0]}));
            model[p] = exp_next(model[p], wr);
            cpu_rd(24'(p * 2), rd);
            case (model[p][14:13])
                2'd0:    chk({"R5 state ", tag}, 32'(rd), 32'(model[p]));
                default: chk({"R3 R4 R6 state ", tag}, 32'(rd), 32'(model[p]));
            endcase
        end
    endtask

    initial begin
        logic [15:0] rd;
        logic [23:0] xa;
        logic        xv;
        logic [23:0] pt [4];

        repeat (3) @(negedge clk);
        chk("R10 xl_valid after reset", 32'(xl_valid), 32'd0);
        chk("R10 rdata after reset", 32'(map_rdata), 32'd0);
        rst_n = 1'b1;
        cpu_rd(24'd10, rd);
        chk("R10 entry 5 reset", 32'(rd), 32'd0);
        cpu_rd(24'd2046, rd);
        chk("R10 entry 1023 reset", 32'(rd), 32'd0);

        // fill and read back every entry
        for (int i = 0; i < 1024; i++) begin
            model[i] = fill_val(i);
            cpu_wr(24'(i * 2), model[i], 1'b1);
        end
        for (int i = 0; i < 1024; i++) begin
            cpu_rd(24'(i * 2), rd);
            chk("R7 word readback", 32'(rd), 32'(model[i]));
        end

        sweep(1'b0, "read pass 1");
        @(negedge clk);
        chk("R2 valid drops when idle", 32'(xl_valid), 32'd0);
        for (int i = 0; i < 1024; i++) begin
            model[i] = fill_val(i);
            cpu_wr(24'(i * 2), model[i], 1'b1);
        end
        sweep(1'b1, "write pass");
        sweep(1'b0, "read pass 2");

        // pass-through: low bits land on fresh pages that must stay fresh
        cpu_wr(24'd0, 16'h2001, 1'b1);       model[0]    = 16'h2001;
        cpu_wr(24'd2046, 16'hA3FF, 1'b1);    model[1023] = 16'hA3FF;
        cpu_wr(24'd2*24'h1A, 16'h201A, 1'b1); model[26]  = 16'h201A;
        pt[0] = 24'h40_0000; pt[1] = 24'hFF_FFFF; pt[2] = 24'hC1_AABC; pt[3] = 24'h7F_F123;
        for (int k = 0; k < 4; k++) begin
            access(pt[k], k[0], xa, xv);
            chk("R1 pass-through address", 32'(xa), 32'(pt[k]));
            cpu_rd(24'(pt[k][21:12]) * 24'd2, rd);
            chk("R1 entry untouched", 32'(rd), 32'(model[pt[k][21:12]]));
        end

        // big-endian byte lanes
        cpu_wr(24'd6, 16'h0000, 1'b1);
        cpu_wr(24'd6, 16'h00AB, 1'b0);
        cpu_rd(24'd6, rd);
        chk("R7 even byte to high half", 32'(rd), 32'h0000_AB00);
        cpu_wr(24'd7, 16'h00CD, 1'b0);
        cpu_rd(24'd6, rd);
        chk("R7 odd byte to low half", 32'(rd), 32'h0000_ABCD);

        // mirror
        cpu_wr(24'h00_080E, 16'h1234, 1'b1);
        cpu_rd(24'd14, rd);
        chk("R8 mirror write", 32'(rd), 32'h1234);
        cpu_rd(24'hFF_F80E, rd);
        chk("R8 mirror read", 32'(rd), 32'h1234);

        // collision on the same entry: CPU wins, translation uses old entry
        cpu_wr(24'd18, 16'h2155, 1'b1);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 24'h00_90AB; acc_write = 1'b0;
        map_req = 1'b1; map_wr = 1'b1; map_word = 1'b1; map_addr = 24'd18; map_wdata = 16'h2077;
        @(negedge clk);
        acc_valid = 1'b0; map_req = 1'b0; map_wr = 1'b0;
        chk("R9 old entry used", 32'(xl_addr), 32'h15_50AB);
        cpu_rd(24'd18, rd);
        chk("R9 CPU write wins", 32'(rd), 32'h2077);

        // update and CPU write to different entries in one cycle
        cpu_wr(24'd18, 16'h2155, 1'b1);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 24'h00_9000; acc_write = 1'b0;
        map_req = 1'b1; map_wr = 1'b1; map_word = 1'b1; map_addr = 24'd20; map_wdata = 16'hBEEF;
        @(negedge clk);
        acc_valid = 1'b0; map_req = 1'b0; map_wr = 1'b0;
        cpu_rd(24'd18, rd);
        chk("R9 update kept on other entry", 32'(rd), 32'h4155);
        cpu_rd(24'd20, rd);
        chk("R9 CPU write on other entry", 32'(rd), 32'hBEEF);

        // back-to-back accesses on one page
        cpu_wr(24'd40, 16'h20AA, 1'b1);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 24'h01_4001; acc_write = 1'b0;
        @(negedge clk);
        chk("R2 back-to-back 1", 32'(xl_addr), 32'h0A_A001);
        acc_addr = 24'h01_4002; acc_write = 1'b0;
        @(negedge clk);
        chk("R2 back-to-back 2", 32'(xl_addr), 32'h0A_A002);
        acc_addr = 24'h01_4003; acc_write = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R2 back-to-back 3", 32'(xl_addr), 32'h0A_A003);
        cpu_rd(24'd40, rd);
        chk("R4 read then write ends dirty", 32'(rd), 32'h60AA);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule